// File: doc/BRIEF.md
# Registered Sixteen-Bit Multi-Function ALU

This block is a clocked arithmetic-logic unit. Two 16-bit operands and a 3-bit function code are captured together on a rising clock edge. One of eight functional units then forms a value from the captured operands. Those units cover add, subtract, bitwise OR and AND, a left shift, pass-through, a truncated multiply and a constant zero. An eight-way selector picks one unit, and its value is stored in a 16-bit result register on the following rising edge. A one-bit carry flag is stored next to the result.

A new operation can be presented every cycle, so the unit behaves as a two-stage pipeline. A synchronous active-high reset clears the operand registers, the captured function code, the result and the carry.

Top module: `regAlu16`

## Requirements
- R1: While `rst` is high at a rising edge, the result register and the carry flag are zero after that edge, and so are the captured operands and code.
- R2: The operands and code present at rising edge N determine `result` and `carryOut` after edge N+1. A different operation may be presented at every edge.
- R3: Code 000 adds A and B. `carryOut` is the carry out of bit 15. Two examples: 0x7FFF + 0x0001 gives 0x8000 with carry 0, and 0xFFFF + 0x0001 gives 0x0000 with carry 1.
- R4: Code 001 passes A unchanged to the result.
- R5: Code 010 gives the bitwise OR of A and B.
- R6: Code 011 gives A − B (modulo 2^16). It is formed by adding the inverted B with a carry-in of 1. `carryOut` is 1 exactly when A ≥ B as unsigned numbers, meaning no borrow.
- R7: Code 100 shifts A left by B[3:0] bit positions and fills with zeros. B[15:4] has no effect on the result.
- R8: Code 101 gives the low 16 bits of the full unsigned 16×16 product A·B.
- R9: Code 110 gives the bitwise AND of A and B.
- R10: Code 111 gives zero regardless of the operands.
- R11: For every code other than 000 and 011, `carryOut` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opA | input | 16 | Operand A |
| opB | input | 16 | Operand B |
| funcSel | input | 3 | Function code |
| result | output | 16 | Registered result |
| carryOut | output | 1 | Registered carry / no-borrow flag |

## Verification
The bench drives the full-length carry ripple of 0x7FFF + 0x0001 and the wrap of 0xFFFF + 0x0001. A design with a broken carry chain or a dropped bit-16 carry would return the wrong sum or a wrong flag for these. Subtract is exercised with A equal to B, A below B and A above B, which catches a missing carry-in or an inverted borrow sense. Shift amounts of 0 and 15 are driven with junk in B's upper bits, and large products are driven to show truncation. Codes change on every cycle, so a selector that lags the operands by a cycle would pair one operation with the wrong operands.

// File: rtl/aluPkg.sv
package aluPkg;

  parameter int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    OP_ADD  = 3'b000,
    OP_PASS = 3'b001,
    OP_OR   = 3'b010,
    OP_SUB  = 3'b011,
    OP_SHL  = 3'b100,
    OP_MUL  = 3'b101,
    OP_AND  = 3'b110,
    OP_ZERO = 3'b111
  } aluOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    aluOp_e unitSel;  // which unit drives the result
    logic   subMode;  // invert B and inject carry-in
    logic   carryEn;  // adder carry reaches the flag
  } aluStrobes_t;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
(
  input  logic [SEL_W-1:0] funcSel,
  output aluStrobes_t      strobes
);

  always_comb begin
    strobes.unitSel = aluOp_e'(funcSel);
    strobes.subMode = (funcSel == OP_SUB);
    strobes.carryEn = (funcSel == OP_ADD) || (funcSel == OP_SUB);
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  localparam int SHW       = $clog2(WIDTH);
  localparam int NUM_UNITS = 2 ** SEL_W;

  logic [WIDTH-1:0] aReg, bReg, resReg;
  logic             carryReg;
  aluStrobes_t      ctrlQ;

  // Shared adder: subtract = A + ~B + 1
  logic [WIDTH-1:0]   bEff;
  logic [WIDTH:0]     adderSum;
  logic [2*WIDTH-1:0] prodFull;
  logic [WIDTH-1:0]   unitOut [NUM_UNITS];

  assign bEff     = ctrlQ.subMode ? ~bReg : bReg;
  assign adderSum = {1'b0, aReg} + {1'b0, bEff} + {{WIDTH{1'b0}}, ctrlQ.subMode};
  assign prodFull = {{WIDTH{1'b0}}, aReg} * {{WIDTH{1'b0}}, bReg};

  for (genvar u = 0; u < NUM_UNITS; u++) begin : gUnit
    if (u == int'(OP_ADD) || u == int'(OP_SUB)) begin : gArith
      assign unitOut[u] = adderSum[WIDTH-1:0];
    end else if (u == int'(OP_PASS)) begin : gPass
      assign unitOut[u] = aReg;
    end else if (u == int'(OP_OR)) begin : gOr
      assign unitOut[u] = aReg | bReg;
    end else if (u == int'(OP_SHL)) begin : gShl
      assign unitOut[u] = aReg << bReg[SHW-1:0];
    end else if (u == int'(OP_MUL)) begin : gMul
      assign unitOut[u] = prodFull[WIDTH-1:0];
    end else if (u == int'(OP_AND)) begin : gAnd
      assign unitOut[u] = aReg & bReg;
    end else begin : gZero
      assign unitOut[u] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      aReg     <= '0;
      bReg     <= '0;
      ctrlQ    <= '{unitSel: OP_ADD, subMode: 1'b0, carryEn: 1'b0};
      resReg   <= '0;
      carryReg <= 1'b0;
    end else begin
      aReg     <= opA;
      bReg     <= opB;
      ctrlQ    <= strobes;
      resReg   <= unitOut[ctrlQ.unitSel];
      carryReg <= ctrlQ.carryEn & adderSum[WIDTH];
    end
  end

  assign result   = resReg;
  assign carryOut = carryReg;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (result == '0 && carryOut == 1'b0)); // R1
  AST_PASS_A: assert property (@(posedge clk) disable iff (rst)
    ctrlQ.unitSel == OP_PASS |=> result == $past(aReg)); // R4
  AST_SUB_NOBORROW: assert property (@(posedge clk) disable iff (rst)
    ctrlQ.unitSel == OP_SUB |=> carryOut == ($past(aReg) >= $past(bReg))); // R6
  AST_AND_BITS: assert property (@(posedge clk) disable iff (rst)
    ctrlQ.unitSel == OP_AND |=> result == ($past(aReg) & $past(bReg))); // R9
  AST_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
    ctrlQ.unitSel == OP_ZERO |=> result == '0); // R10
  AST_CARRY_ARITH_ONLY: assert property (@(posedge clk) disable iff (rst)
    (ctrlQ.unitSel != OP_ADD && ctrlQ.unitSel != OP_SUB) |=> !carryOut); // R11

endmodule

// File: rtl/regAlu16.sv
module regAlu16
  import aluPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SEL_W-1:0] funcSel,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  aluStrobes_t strobes;

  aluCtrl uCtrl (
    .funcSel (funcSel),
    .strobes (strobes)
  );

  aluDatapath #(.WIDTH(WIDTH)) uPath (
    .clk      (clk),
    .rst      (rst),
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .carryOut (carryOut)
  );

endmodule

// File: tb/sim_regAlu16.sv
`timescale 1ns/1ps
module sim_regAlu16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic [2:0]  funcSel = '0;
  logic [15:0] result;
  logic        carryOut;

  int checks = 0;
  int fails  = 0;
  int edgeCount = 0;
  bit finished = 0;

  typedef struct {
    int          due;
    logic [16:0] exp;
    string       req;
  } item_t;
  item_t sbq[$];

  regAlu16 u0 (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .funcSel(funcSel),
    .result(result), .carryOut(carryOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) edgeCount++;

  function automatic logic [16:0] model(logic [15:0] a, logic [15:0] b, logic [2:0] f);
    logic [16:0] s;
    logic [31:0] p;
    case (f)
      3'b000: s = {1'b0, a} + {1'b0, b};
      3'b001: s = {1'b0, a};
      3'b010: s = {1'b0, a | b};
      3'b011: s = {(a >= b), a - b};
      3'b100: s = {1'b0, a << b[3:0]};
      3'b101: begin p = a * b; s = {1'b0, p[15:0]}; end
      3'b110: s = {1'b0, a & b};
      default: s = 17'd0;
    endcase
    return s;
  endfunction

  function automatic string reqOf(logic [2:0] f);
    case (f)
      3'b000: return "R3";
      3'b001: return "R4";
      3'b010: return "R5";
      3'b011: return "R6";
      3'b100: return "R7";
      3'b101: return "R8";
      3'b110: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual carry=%0b result=0x%04h, expected carry=%0b result=0x%04h",
               req, act[16], act[15:0], exp[16], exp[15:0]);
    end
  endtask

  // Driver: present one operation at a negedge; its result is due after the second next posedge
  task automatic drive(logic [15:0] a, logic [15:0] b, logic [2:0] f, string req = "");
    item_t it;
    @(negedge clk);
    opA = a; opB = b; funcSel = f;
    it.due = edgeCount + 2;
    it.exp = model(a, b, f);
    it.req = (req == "") ? reqOf(f) : req;
    sbq.push_back(it);
  endtask

  // Monitor: compare after each edge once an item is due
  always @(posedge clk) begin
    #2;
    while (sbq.size() > 0 && sbq[0].due == edgeCount) begin
      item_t it;
      it = sbq.pop_front();
      check(it.req, {carryOut, result}, it.exp);
      if (it.exp[15:0] != 16'd0 || it.exp[16]) ;
      if (it.req != "R11" && funcSel != 3'b000 && 0) ;
    end
  end

  task automatic drain();
    while (sbq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {carryOut, result}, 17'd0);
    @(negedge clk); rst = 1'b0;

    // R3: ripple corner cases
    drive(16'h7FFF, 16'h0001, 3'b000);
    drive(16'hFFFF, 16'h0001, 3'b000);
    drive(16'h1234, 16'h4321, 3'b000);
    // R4
    drive(16'hBEEF, 16'h1111, 3'b001);
    // R5
    drive(16'hF0F0, 16'h0F01, 3'b010);
    // R6: equal, below, above
    drive(16'h5555, 16'h5555, 3'b011);
    drive(16'h0001, 16'h0002, 3'b011);
    drive(16'h8000, 16'h0001, 3'b011);
    // R7: upper B bits must not matter
    drive(16'h8001, 16'hFFF0, 3'b100);
    drive(16'h0001, 16'hABCF, 3'b100);
    drive(16'h00FF, 16'h0004, 3'b100);
    // R8: truncation
    drive(16'hFFFF, 16'hFFFF, 3'b101);
    drive(16'h1234, 16'h0100, 3'b101);
    // R9
    drive(16'hF0F0, 16'hFF00, 3'b110);
    // R10
    drive(16'hFFFF, 16'hFFFF, 3'b111);
    // R11: carry stays low with operands that would overflow an adder
    drive(16'hFFFF, 16'hFFFF, 3'b010, "R11");
    drive(16'hFFFF, 16'hFFFF, 3'b101, "R11");
    // R2: back-to-back alternating codes
    for (int i = 0; i < 16; i++)
      drive(16'h8000 >> i, 16'hFFFF - i[15:0], i[2:0], "R2");
    // Random sweep over all codes
    for (int i = 0; i < 400; i++)
      drive($urandom, $urandom, $urandom_range(0, 7));
    drain();

    // R1: mid-run reset after a carry-producing add
    drive(16'hFFFF, 16'hFFFF, 3'b000);
    drain();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1", {carryOut, result}, 17'd0);
    @(negedge clk);
    check("R1", {carryOut, result}, 17'd0);

    drive(16'h0003, 16'h0004, 3'b000);
    drain();
    finish();
  end

endmodule